// File: doc/BRIEF.md
# Partitioned-LRU Four-Way Read Cache

This block sits between a bus requester and a slow non-volatile memory and serves reads from a small four-way set-associative store. Every request carries a flag that marks it as an instruction fetch or a data reference. A hit is answered on the clock after the request is accepted. A miss stalls the requester, reads one word-sized line from the backing memory and places it in a victim way. The backing memory may take any number of cycles to answer.

Victim selection follows a per-set age order of the four ways. A two-bit mode input chooses how the ways are divided between the two access types. The ways can be shared by both types, split two and two, or split three and one. Two enable inputs decide separately whether instruction fetches and data references may use the cache at all. A flush input empties the cache in one cycle.

Top module: `partitioned_lru_cache`

## Requirements
- R1: Lookup compares the tag in all four ways of the indexed set (index = low address bits), whatever the mode. A hit raises `rsp_valid` with `rsp_hit`=1, the stored word on `rsp_data`, and the hitting way on `rsp_way`, on the clock after acceptance. It issues no backing read.
- R2: On a miss, `req_ready` drops and `mem_req` is held high with a stable `mem_addr` equal to the request address until `mem_rvalid`. On the clock after `mem_rvalid`, `rsp_valid` rises with `rsp_hit`=0 and `rsp_data` equal to `mem_rdata`.
- R3: Each set keeps an age order of its ways. A hit or a fill makes the touched way the newest. After reset or flush, way 0 is the oldest and way 3 the newest.
- R4: In mode 0, a miss fills the oldest of all four ways. Mode 3 behaves as mode 0. `rsp_way` reports the filled way.
- R5: In mode 1, instruction misses fill the older of ways 0 and 1, and data misses fill the older of ways 2 and 3.
- R6: In mode 2, instruction misses fill the oldest of ways 0 to 2, and data misses always fill way 3.
- R7: When the enable for a request's type is low, the request never hits. It reads the backing memory, reports `rsp_way`=0 and `rsp_hit`=0, and changes neither the stored lines nor the age order.
- R8: A one-cycle `flush` invalidates every line and restores the reset age order.
- R9: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_req`=0, and the cache holds no valid line.
- R10: A line filled under one mode or access type hits for either access type under any other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Way partition mode (0 shared, 1 two plus two, 2 three plus one, 3 as 0) |
| cfg_en_instr | input | 1 | Allow caching of instruction fetches |
| cfg_en_data | input | 1 | Allow caching of data references |
| flush | input | 1 | Invalidate all lines and reset age order |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| req_is_data | input | 1 | 1 = data reference, 0 = instruction fetch |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_way | output | 2 | Way that hit or was filled |
| rsp_data | output | DATA_W | Response word |
| mem_req | output | 1 | Backing read outstanding |
| mem_addr | output | ADDR_W | Backing read address |
| mem_rvalid | input | 1 | Backing read data valid |
| mem_rdata | input | DATA_W | Backing read data |

## Verification
The bench walks one set through a long sequence of fills and hits across all modes. The sequence is chosen so that the oldest way sits in a different position each time. A design with a wrong age update or a partition mask that ignores the access type would therefore pick the wrong victim and report a wrong `rsp_way`. Hits on ways filled under an earlier mode catch a lookup that is wrongly limited to the current partition. The bench also turns off the enable for one access type and then turns it back on. A disabled request that still allocated or aged a way would turn a later expected hit into a miss, or shift the next victim. Other cases cover a flush followed by a miss on a line that was just cached, which must land in way 0. Backing latencies of one to four cycles catch a response that is not tied to the memory's data strobe.

// File: rtl/plc_pkg.sv
package plc_pkg;

  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } ctrl_state_e;

  // Ways a miss of the given access type may fill in the given mode.
  function automatic logic [WAYS-1:0] fill_mask(input logic [1:0] mode,
                                                input logic       is_data);
    case (mode)
      2'd1:    return is_data ? 4'b1100 : 4'b0011;
      2'd2:    return is_data ? 4'b1000 : 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/plc_store.sv
module plc_store
  import plc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [WAYS-1:0]   hit_vec,
  output logic [DATA_W-1:0] hit_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);

  logic [SETS-1:0][WAYS-1:0] vld_q, vld_d;
  logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
  logic [DATA_W-1:0]         data_q [SETS][WAYS];

  always_comb begin
    vld_d = vld_q;
    if (flush) begin
      vld_d = '0;
    end else if (fill_en) begin
      vld_d[fill_idx][fill_way] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx][fill_way]  <= fill_tag;
      data_q[fill_idx][fill_way] <= fill_data;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_data = hit_data | data_q[lk_idx][w];
    end
  end

  // R1
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (hit_vec == '0));

endmodule

// File: rtl/plc_age.sv
module plc_age
  import plc_pkg::*;
#(
  parameter int SETS   = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] q_idx,
  input  logic [WAYS-1:0]  allow,
  output logic [WAY_W-1:0] victim
);

  // Age 0 is newest, 3 is oldest; way 0 starts oldest.
  localparam logic [WAYS-1:0][1:0] AGE_INIT = {2'd0, 2'd1, 2'd2, 2'd3};

  logic [SETS-1:0][WAYS-1:0][1:0] age_q, age_d;

  always_comb begin
    age_d = age_q;
    if (flush) begin
      age_d = {SETS{AGE_INIT}};
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[touch_idx][w] < age_q[touch_idx][touch_way])
          age_d[touch_idx][w] = age_q[touch_idx][w] + 2'd1;
      end
      age_d[touch_idx][touch_way] = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= {SETS{AGE_INIT}};
    else        age_q <= age_d;
  end

  always_comb begin
    logic       found;
    logic [1:0] best;
    found  = 1'b0;
    best   = 2'd0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (allow[w] && (!found || age_q[q_idx][w] > best)) begin
        found  = 1'b1;
        best   = age_q[q_idx][w];
        victim = WAY_W'(w);
      end
    end
  end

  // R3
  touch_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && !flush) |=> (age_q[$past(touch_idx)][$past(touch_way)] == 2'd0));

  // R4
  victim_in_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (allow != '0) |-> allow[victim]);

endmodule

// File: rtl/plc_ctrl.sv
module plc_ctrl
  import plc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              type_on,
  input  logic              lk_hit,
  input  logic [WAY_W-1:0]  hit_way,
  input  logic [DATA_W-1:0] hit_data,
  input  logic [WAY_W-1:0]  victim,
  output logic              touch_en,
  output logic [WAY_W-1:0]  touch_way,
  output logic              fill_en,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [DATA_W-1:0] rsp_data
);

  ctrl_state_e       state_q, state_d;
  logic [ADDR_W-1:0] cap_addr_q;
  logic              cap_alloc_q;
  logic [WAY_W-1:0]  cap_way_q;

  logic              acc, hit_take, miss_take, fetch_done;
  logic              rsp_valid_d, rsp_hit_d;
  logic [WAY_W-1:0]  rsp_way_d;
  logic [DATA_W-1:0] rsp_data_d;

  assign req_ready  = (state_q == ST_IDLE);
  assign acc        = req_valid && req_ready;
  assign hit_take   = acc && lk_hit;
  assign miss_take  = acc && !lk_hit;
  assign mem_req    = (state_q == ST_FETCH);
  assign mem_addr   = cap_addr_q;
  assign fetch_done = mem_req && mem_rvalid;

  assign fill_en   = fetch_done && cap_alloc_q;
  assign touch_en  = hit_take || fill_en;
  assign touch_way = mem_req ? cap_way_q : hit_way;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (miss_take)  state_d = ST_FETCH;
      ST_FETCH: if (mem_rvalid) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rsp_valid_d = hit_take || fetch_done;
    rsp_hit_d   = hit_take;
    rsp_way_d   = hit_take ? hit_way : (cap_alloc_q ? cap_way_q : '0);
    rsp_data_d  = hit_take ? hit_data : mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cap_addr_q  <= '0;
      cap_alloc_q <= 1'b0;
      cap_way_q   <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_way     <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_valid_d;
      if (miss_take) begin
        cap_addr_q  <= req_addr;
        cap_alloc_q <= type_on;
        cap_way_q   <= victim;
      end
      if (rsp_valid_d) begin
        rsp_hit <= rsp_hit_d;
        rsp_way <= rsp_way_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_d) rsp_data <= rsp_data_d;
  end

  // R1
  hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_take |=> (rsp_valid && rsp_hit && !mem_req));

  // R2
  miss_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (rsp_valid && !rsp_hit && req_ready));

  // R2
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && !rsp_valid));

endmodule

// File: rtl/partitioned_lru_cache.sv
module partitioned_lru_cache
  import plc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_en_instr,
  input  logic              cfg_en_data,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_way,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              type_on, lk_hit;
  logic [WAYS-1:0]   hit_vec, allow;
  logic [WAY_W-1:0]  hit_way, victim, touch_way;
  logic [DATA_W-1:0] hit_data;
  logic              touch_en, fill_en;
  logic [IDX_W-1:0]  touch_idx;

  assign type_on = req_is_data ? cfg_en_data : cfg_en_instr;
  assign lk_hit  = type_on && (hit_vec != '0);
  assign allow   = fill_mask(cfg_mode, req_is_data);
  assign touch_idx = mem_req ? mem_addr[IDX_W-1:0] : req_addr[IDX_W-1:0];

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  plc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_idx    (req_addr[IDX_W-1:0]),
    .lk_tag    (req_addr[ADDR_W-1:IDX_W]),
    .hit_vec   (hit_vec),
    .hit_data  (hit_data),
    .fill_en   (fill_en),
    .fill_idx  (mem_addr[IDX_W-1:0]),
    .fill_way  (touch_way),
    .fill_tag  (mem_addr[ADDR_W-1:IDX_W]),
    .fill_data (mem_rdata)
  );

  plc_age #(.SETS(SETS)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .touch_way (touch_way),
    .q_idx     (req_addr[IDX_W-1:0]),
    .allow     (allow),
    .victim    (victim)
  );

  plc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .type_on    (type_on),
    .lk_hit     (lk_hit),
    .hit_way    (hit_way),
    .hit_data   (hit_data),
    .victim     (victim),
    .touch_en   (touch_en),
    .touch_way  (touch_way),
    .fill_en    (fill_en),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_way    (rsp_way),
    .rsp_data   (rsp_data)
  );

  // R7
  bypass_reads_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !type_on) |=> (mem_req && !rsp_valid));

  // R10
  any_part_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && type_on && (hit_vec != '0)) |=> rsp_hit);

endmodule

// File: tb/tb_partitioned_lru_cache.sv
module tb_partitioned_lru_cache;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic        cfg_en_instr, cfg_en_data, flush;
  logic        req_valid, req_ready, req_is_data;
  logic [15:0] req_addr;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_way;
  logic [31:0] rsp_data;
  logic        mem_req, mem_rvalid;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  int lat    = 1;
  int lcnt   = 0;

  always #5 clk = ~clk;

  partitioned_lru_cache dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_en_instr(cfg_en_instr),
    .cfg_en_data(cfg_en_data), .flush(flush), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_is_data(req_is_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_data(rsp_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // Backing memory: answers lat cycles after the read appears.
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      lcnt       <= 0;
    end else if (mem_req && !mem_rvalid) begin
      if (lcnt >= lat - 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= {~mem_addr, mem_addr};
        lcnt       <= 0;
      end else begin
        lcnt <= lcnt + 1;
      end
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  // Fields: [13:12] mode, [11] data flag, [10:3] tag, [2] hit, [1:0] way
  localparam logic [13:0] VEC [0:18] = '{
    {2'd0, 1'b0, 8'd1,  1'b0, 2'd0},
    {2'd0, 1'b1, 8'd2,  1'b0, 2'd1},
    {2'd0, 1'b0, 8'd3,  1'b0, 2'd2},
    {2'd0, 1'b1, 8'd4,  1'b0, 2'd3},
    {2'd0, 1'b0, 8'd1,  1'b1, 2'd0},
    {2'd0, 1'b1, 8'd5,  1'b0, 2'd1},
    {2'd0, 1'b1, 8'd2,  1'b0, 2'd2},
    {2'd1, 1'b0, 8'd6,  1'b0, 2'd0},
    {2'd1, 1'b1, 8'd7,  1'b0, 2'd3},
    {2'd1, 1'b0, 8'd4,  1'b0, 2'd1},
    {2'd1, 1'b1, 8'd6,  1'b1, 2'd0},
    {2'd1, 1'b1, 8'd8,  1'b0, 2'd2},
    {2'd2, 1'b1, 8'd9,  1'b0, 2'd3},
    {2'd2, 1'b1, 8'd10, 1'b0, 2'd3},
    {2'd2, 1'b0, 8'd11, 1'b0, 2'd1},
    {2'd2, 1'b0, 8'd10, 1'b1, 2'd3},
    {2'd2, 1'b0, 8'd12, 1'b0, 2'd0},
    {2'd3, 1'b1, 8'd13, 1'b0, 2'd2},
    {2'd0, 1'b0, 8'd8,  1'b0, 2'd1}
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_req(input logic dat, input logic [15:0] addr,
                        input logic exp_hit, input logic [1:0] exp_way,
                        input string rq);
    int  waited;
    bit  bad;
    @(negedge clk);
    req_valid   = 1'b1;
    req_is_data = dat;
    req_addr    = addr;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    bad    = 1'b0;
    while (!rsp_valid && waited < 200) begin
      if (!mem_req || req_ready || mem_addr != addr) bad = 1'b1;
      @(negedge clk);
      waited++;
    end
    chk(rsp_valid === 1'b1, "R2", "response present", 32'(rsp_valid), 32'd1);
    chk(rsp_hit === exp_hit, rq, "hit flag", 32'(rsp_hit), 32'(exp_hit));
    chk(rsp_way === exp_way, rq, "way", 32'(rsp_way), 32'(exp_way));
    chk(rsp_data === {~addr, addr}, exp_hit ? "R1" : "R2", "data",
        rsp_data, {~addr, addr});
    if (exp_hit)
      chk(waited == 0 && !mem_req, "R1", "hit latency", 32'(waited), 32'd0);
    else
      chk(!bad && waited >= 1 && mem_rvalid, "R2", "miss handshake",
          32'(bad), 32'd0);
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'd1:    return "R5";
      2'd2:    return "R6";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    rst_n        = 1'b0;
    cfg_mode     = 2'd0;
    cfg_en_instr = 1'b1;
    cfg_en_data  = 1'b1;
    flush        = 1'b0;
    req_valid    = 1'b0;
    req_is_data  = 1'b0;
    req_addr     = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(req_ready === 1'b1, "R9", "ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R9", "no response after reset", 32'(rsp_valid), 32'd0);
    chk(mem_req === 1'b0, "R9", "no read after reset", 32'(mem_req), 32'd0);

    // Table walk on set 1; victims follow R3 age order, hits in rows 11 and 16 cover R10
    for (int i = 0; i < 19; i++) begin
      cfg_mode = VEC[i][13:12];
      lat      = 1 + (i % 4);
      do_req(VEC[i][11], {5'd0, VEC[i][10:3], 3'd1}, VEC[i][2], VEC[i][1:0],
             VEC[i][2] ? "R10" : mode_req(VEC[i][13:12]));
    end

    // R8 flush: line just cached misses and refills way 0 (R3 reset order)
    cfg_mode = 2'd0;
    lat      = 2;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    do_req(1'b0, {5'd0, 8'd8, 3'd1}, 1'b0, 2'd0, "R8");

    // R7 disabled type: no hit, no fill, no age change
    do_req(1'b0, {5'd0, 8'd20, 3'd2}, 1'b0, 2'd0, "R7");
    cfg_en_instr = 1'b0;
    do_req(1'b0, {5'd0, 8'd20, 3'd2}, 1'b0, 2'd0, "R7");
    cfg_en_instr = 1'b1;
    do_req(1'b0, {5'd0, 8'd20, 3'd2}, 1'b1, 2'd0, "R7");
    cfg_en_data = 1'b0;
    lat = 3;
    do_req(1'b1, {5'd0, 8'd21, 3'd2}, 1'b0, 2'd0, "R7");
    cfg_en_data = 1'b1;
    do_req(1'b1, {5'd0, 8'd21, 3'd2}, 1'b0, 2'd1, "R7");
    do_req(1'b1, {5'd0, 8'd21, 3'd2}, 1'b1, 2'd1, "R1");

    repeat (2) @(negedge clk);
    report();
  end

endmodule